// File: doc/BRIEF.md
# Switched-Circuit Timestep Solver Engine

This block advances a fixed-point circuit simulation by one time step each time it is strobed. The circuit is described offline as a set of companion models. Every element is reduced to a conductance in parallel with a history current source. Switching devices keep a constant conductance whatever their state, so the inverse of the nodal admittance matrix is a fixed set of coefficients that never needs to be rebuilt. The ON or OFF state of a switch changes only how its history source is updated. A switch and its snubber are merged into one equivalent conductance and one history source.

A step runs in two phases. The first phase solves all node voltages at once. Each node voltage is a row of the constant inverse matrix times the vector of injected currents. The injected current at a node is the external source value plus the history current from the previous step. The second phase then refreshes every history source from the new voltages. The new value is a weighted sum of the node voltage and the old history current. A switching source takes its weights from one of two constant pairs, chosen by its gate bit. Gate bits pass through a two-flop synchronizer and are captured when the step starts. The results appear on the outputs on the clock edge that completes the step, and a one-cycle done pulse marks that edge.

Top module: `sct_step_engine`

## Requirements
- R1: While reset is active and after it is released, `done` is low and `node_v` is zero. All history currents are cleared to zero, so the first step after reset yields node voltages computed with zero history.
- R2: For each node i, the new voltage is `sat(sum_j rnd(Z[i][j] * inj[j]))` with `inj[j] = sat(ext[j] + hist[j])`. `hist` is the history from the previous step, and `ext[j]` is the field `ext_src[j*W +: W]` captured at the strobe. `node_v[i*W +: W]` carries node i.
- R3: History source k is connected at node k. After the voltages are solved, it becomes `sat(rnd(a_k * v[k]) + rnd(b_k * hist[k]))`. The next step uses this new value as its history current.
- R4: Sources 0..NSW-1 are switches, and source k is selected by `gate_in[k]`. A gate value of 1 uses the pair (COEF_A1, COEF_B1) and 0 uses (COEF_A0, COEF_B0). Sources with index NSW or higher always use (COEF_A0, COEF_B0).
- R5: The gate bits and external sources are captured on the edge that accepts the strobe. Changes to `gate_in` or `ext_src` after that edge do not affect the step in progress.
- R6: The gate path has two synchronizer flops. A gate value first presented two edges before the accepting edge is used. A value first presented only one edge before it is not used, and the older value applies.
- R7: A strobe is accepted at a rising edge when the engine is idle and `step_go` is high. `done` is high for exactly one cycle, after the second rising edge that follows the accepting edge. `node_v` changes only on that same edge.
- R8: A `step_go` that is high while a step is in progress is ignored: it produces no extra done pulse and no output change.
- R9: All values are signed Q-format with FRAC fractional bits. A product is rounded half-up as `(p + 2^(FRAC-1)) >>> FRAC`. Every adder output saturates to the range -2^(W-1) .. 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_go | input | 1 | Step strobe |
| gate_in | input | NSW | Asynchronous gate bits, one per switch |
| ext_src | input | N*W | External source current per node, packed |
| node_v | output | N*W | Solved node voltages, packed |
| done | output | 1 | One-cycle pulse when a step completes |

## Verification
The hardest situations to reach from the ports involve the gate bits. One is a gate flip that lands after the strobe has been accepted. The other is a flip that lands inside the two-edge synchronizer window. In both cases the only visible sign is which coefficient pair shaped the history, and that shows up only on the next step's voltages. The stimulus places gate flips one edge before the strobe and on the cycle just after it. It then checks the following step against a model that used the older gate value. Saturation is reached with directed full-scale sources on top of random accumulated history.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SOLVE  = 2'd1,
    PH_UPDATE = 2'd2
  } phase_e;
endpackage

// File: rtl/sct_gate_sync.sv
module sct_gate_sync #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_i_n,
  input  logic [NB-1:0] async_i,
  output logic [NB-1:0] sync_o
);
  logic [NB-1:0] s1_q;
  logic [NB-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/sct_node_solve.sv
module sct_node_solve #(
  parameter int N    = 3,
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter logic [N*N*W-1:0] ZMAT = '0
) (
  input  logic [N*W-1:0] ext_i,
  input  logic [N*W-1:0] hist_i,
  output logic [N*W-1:0] v_o
);
  localparam int ACC_W = 2*W + $clog2(N) + 1;
  localparam logic signed [ACC_W-1:0] SMAX = {{(ACC_W-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SMIN = {{(ACC_W-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [2*W-1:0]   RC   = {{(2*W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] rnd_mul(input logic signed [W-1:0] a,
                                                      input logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = (a * b + RC) >>> FRAC;
    return {{(ACC_W-2*W){p[2*W-1]}}, p};
  endfunction

  function automatic logic [W-1:0] sat(input logic signed [ACC_W-1:0] s);
    if (s > SMAX)      return SMAX[W-1:0];
    else if (s < SMIN) return SMIN[W-1:0];
    else               return s[W-1:0];
  endfunction

  logic [N*W-1:0] inj;

  for (genvar j = 0; j < N; j++) begin : g_inj
    logic signed [W-1:0] e_s, h_s;
    assign e_s = ext_i[j*W +: W];
    assign h_s = hist_i[j*W +: W];
    assign inj[j*W +: W] = sat(ACC_W'(e_s) + ACC_W'(h_s));
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    logic signed [ACC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < N; j++) begin
        acc = acc + rnd_mul(ZMAT[(i*N+j)*W +: W], inj[j*W +: W]);
      end
    end
    assign v_o[i*W +: W] = sat(acc);
  end
endmodule

// File: rtl/sct_hist_update.sv
module sct_hist_update #(
  parameter int N    = 3,
  parameter int NSW  = 2,
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter logic [N*W-1:0] COEF_A1 = '0,
  parameter logic [N*W-1:0] COEF_B1 = '0,
  parameter logic [N*W-1:0] COEF_A0 = '0,
  parameter logic [N*W-1:0] COEF_B0 = '0
) (
  input  logic [N*W-1:0] v_i,
  input  logic [N*W-1:0] hist_i,
  input  logic [NSW-1:0] gate_i,
  output logic [N*W-1:0] hist_o
);
  localparam int ACC_W = 2*W + 2;
  localparam logic signed [ACC_W-1:0] SMAX = {{(ACC_W-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SMIN = {{(ACC_W-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [2*W-1:0]   RC   = {{(2*W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] rnd_mul(input logic signed [W-1:0] a,
                                                      input logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = (a * b + RC) >>> FRAC;
    return {{(ACC_W-2*W){p[2*W-1]}}, p};
  endfunction

  function automatic logic [W-1:0] sat(input logic signed [ACC_W-1:0] s);
    if (s > SMAX)      return SMAX[W-1:0];
    else if (s < SMIN) return SMIN[W-1:0];
    else               return s[W-1:0];
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_src
    logic [W-1:0] ca, cb;
    if (k < NSW) begin : g_switch
      // R4: gate bit k picks the coefficient pair
      assign ca = gate_i[k] ? COEF_A1[k*W +: W] : COEF_A0[k*W +: W];
      assign cb = gate_i[k] ? COEF_B1[k*W +: W] : COEF_B0[k*W +: W];
    end else begin : g_fixed
      assign ca = COEF_A0[k*W +: W];
      assign cb = COEF_B0[k*W +: W];
    end
    assign hist_o[k*W +: W] = sat(rnd_mul(ca, v_i[k*W +: W]) + rnd_mul(cb, hist_i[k*W +: W]));
  end
endmodule

// File: rtl/sct_step_engine.sv
module sct_step_engine #(
  parameter int N    = 3,
  parameter int NSW  = 2,
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter logic [N*N*W-1:0] ZMAT = {16'h0C00, 16'hFD00, 16'h0100,
                                      16'hFD00, 16'h0600, 16'h0200,
                                      16'h0A00, 16'h0200, 16'h0800},
  parameter logic [N*W-1:0] COEF_A1 = {16'h0000, 16'h0A00, 16'h0C00},
  parameter logic [N*W-1:0] COEF_B1 = {16'h0000, 16'hF800, 16'hF000},
  parameter logic [N*W-1:0] COEF_A0 = {16'h0400, 16'h0100, 16'h0080},
  parameter logic [N*W-1:0] COEF_B0 = {16'h0E00, 16'h0400, 16'h0800}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_go,
  input  logic [NSW-1:0] gate_in,
  input  logic [N*W-1:0] ext_src,
  output logic [N*W-1:0] node_v,
  output logic           done
);
  import sct_pkg::*;

  // reset: asserted asynchronously, released after two clock edges
  logic rs1_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_i_n <= rs1_q;
    end
  end

  logic [NSW-1:0] gate_s, gate_lat_q;
  logic [N*W-1:0] ext_q, v_q, hist_q, node_v_q;
  logic [N*W-1:0] v_next, hist_next;
  logic           done_q;
  phase_e         state_q, state_d;
  logic           lat_en, solve_en, upd_en;

  sct_gate_sync #(.NB(NSW)) u_sync (
    .clk(clk), .rst_i_n(rst_i_n), .async_i(gate_in), .sync_o(gate_s)
  );

  sct_node_solve #(.N(N), .W(W), .FRAC(FRAC), .ZMAT(ZMAT)) u_solve (
    .ext_i(ext_q), .hist_i(hist_q), .v_o(v_next)
  );

  sct_hist_update #(.N(N), .NSW(NSW), .W(W), .FRAC(FRAC),
    .COEF_A1(COEF_A1), .COEF_B1(COEF_B1), .COEF_A0(COEF_A0), .COEF_B0(COEF_B0)) u_hist (
    .v_i(v_q), .hist_i(hist_q), .gate_i(gate_lat_q), .hist_o(hist_next)
  );

  assign lat_en   = (state_q == PH_IDLE) && step_go;
  assign solve_en = (state_q == PH_SOLVE);
  assign upd_en   = (state_q == PH_UPDATE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE:   if (step_go) state_d = PH_SOLVE;
      PH_SOLVE:  state_d = PH_UPDATE;
      PH_UPDATE: state_d = PH_IDLE;
      default:   state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q    <= PH_IDLE;
      gate_lat_q <= '0;
      ext_q      <= '0;
      v_q        <= '0;
      hist_q     <= '0;
      node_v_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= upd_en;
      if (lat_en) begin
        gate_lat_q <= gate_s;
        ext_q      <= ext_src;
      end
      if (solve_en) v_q <= v_next;
      if (upd_en) begin
        hist_q   <= hist_next;
        node_v_q <= v_q;
      end
    end
  end

  assign node_v = node_v_q;
  assign done   = done_q;

  // done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  // outputs move only with the completion pulse
  assert_out_with_done_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(node_v) |-> done);
  // completion only follows the update phase
  assert_done_after_update_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> $past(state_q) == PH_UPDATE);
  // history is untouched outside the update phase
  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != PH_UPDATE) |=> $stable(hist_q));
  // captured gates and sources hold through a step in progress
  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != PH_IDLE) |=> ($stable(gate_lat_q) && $stable(ext_q)));
  // a strobe while busy never restarts the sequence
  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == PH_SOLVE) |=> (state_q == PH_UPDATE));
endmodule

// File: tb/sct_step_engine_tb.sv
`timescale 1ns/1ps
module sct_step_engine_tb;
  localparam int N = 3, NSW = 2, W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           step_go;
  logic [NSW-1:0] gate_in;
  logic [N*W-1:0] ext_src;
  logic [N*W-1:0] node_v;
  logic           done;

  always #2.5 clk = ~clk;

  sct_step_engine u_dut (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .gate_in(gate_in),
    .ext_src(ext_src), .node_v(node_v), .done(done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // model coefficients written from the requirements
  int zm[3][3] = '{'{2048, 512, 2560}, '{512, 1536, -768}, '{256, -768, 3072}};
  int a1[3] = '{3072, 2560, 0};
  int b1[3] = '{-4096, -2048, 0};
  int a0[3] = '{128, 256, 1024};
  int b0[3] = '{2048, 1024, 3584};
  int hist[3];
  int vexp[3];

  function automatic int sat(longint s);
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return int'(s);
  endfunction

  function automatic longint rnd(longint a, longint b);
    longint p;
    p = a * b + 2048;
    return p >>> 12;
  endfunction

  function automatic void model_step(int ext[3], logic [NSW-1:0] g);
    int inj[3];
    longint acc;
    for (int j = 0; j < 3; j++) inj[j] = sat(longint'(ext[j]) + hist[j]);
    for (int i = 0; i < 3; i++) begin
      acc = 0;
      for (int j = 0; j < 3; j++) acc += rnd(zm[i][j], inj[j]);
      vexp[i] = sat(acc);
    end
    for (int k = 0; k < 3; k++) begin
      if (k < NSW && g[k]) hist[k] = sat(rnd(a1[k], vexp[k]) + rnd(b1[k], hist[k]));
      else                 hist[k] = sat(rnd(a0[k], vexp[k]) + rnd(b0[k], hist[k]));
    end
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_outputs(string tag);
    for (int i = 0; i < N; i++)
      chk(tag, longint'($signed(node_v[i*W +: W])), vexp[i]);
  endtask

  // mode: 0 plain, 1 mid-step flip, 2 busy strobe, 3 late gate change
  task automatic run_step(int ext[3], logic [NSW-1:0] g, string tag, int mode);
    logic [N*W-1:0] prev;
    @(negedge clk);
    gate_in = g;
    repeat (3) @(negedge clk);
    if (mode == 3) begin
      gate_in = ~g;            // R6: only one edge before the strobe
      @(negedge clk);
    end
    for (int j = 0; j < N; j++) ext_src[j*W +: W] = W'(ext[j]);
    step_go = 1'b1;
    @(negedge clk);            // accepting edge passed
    step_go = 1'b0;
    if (mode == 1) begin       // R5: late changes after capture
      gate_in = ~gate_in;
      ext_src = {$urandom, $urandom};
    end
    if (mode == 2) step_go = 1'b1;  // R8
    @(negedge clk);
    step_go = 1'b0;
    chk("R7 done low one cycle after accept", done, 0);
    model_step(ext, g);
    @(negedge clk);
    chk("R7 done high two cycles after accept", done, 1);
    chk_outputs(tag);
    prev = node_v;
    @(negedge clk);
    chk("R7 done single cycle", done, 0);
    if (mode == 2) begin
      repeat (3) @(negedge clk);
      chk("R8 no extra done", done, 0);
      chk("R8 outputs unchanged", node_v == prev, 1);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e[3];
    void'($urandom(32'd11));
    rst_n = 1'b0; step_go = 1'b0; gate_in = '0; ext_src = '0;
    for (int k = 0; k < 3; k++) hist[k] = 0;
    repeat (4) @(negedge clk);
    chk("R1 done low in reset", done, 0);
    chk("R1 node_v zero in reset", node_v, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done low after reset", done, 0);
    chk("R1 node_v zero after reset", node_v, 0);

    e = '{4096, -2048, 1000};
    run_step(e, 2'b11, "R1 first step zero history", 0);
    e = '{0, 0, 0};
    run_step(e, 2'b11, "R3 history only", 0);
    run_step(e, 2'b00, "R4 gates off", 0);
    e = '{1500, 700, -3000};
    run_step(e, 2'b01, "R4 mixed gates", 0);
    run_step(e, 2'b10, "R5 mid-step change", 1);
    run_step(e, 2'b01, "R6 late gate change", 3);
    e = '{-1200, 2500, 400};
    run_step(e, 2'b11, "R8 busy strobe", 2);
    e = '{32767, 32767, 32767};
    run_step(e, 2'b00, "R9 positive saturation", 0);
    run_step(e, 2'b11, "R9 saturated history", 0);
    e = '{-32768, -32768, -32768};
    run_step(e, 2'b10, "R9 negative saturation", 0);

    for (int t = 0; t < 60; t++) begin
      for (int j = 0; j < 3; j++)
        e[j] = (t % 7 == 0) ? int'($signed(16'($urandom))) : (int'($urandom % 16384) - 8192);
      run_step(e, 2'($urandom), "R2 random step", 0);
    end

    // reset again clears history (R1)
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 node_v zero on second reset", node_v, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) hist[k] = 0;
    repeat (4) @(negedge clk);
    e = '{2000, 2000, 2000};
    run_step(e, 2'b11, "R1 history cleared", 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule